// File: doc/BRIEF.md
# DDR2 Mode-Register Initialization Sequencer

This block carries out the last stretch of DDR2-SDRAM bring-up without software help. After a single start pulse it writes the main mode register (CAS latency and burst length, DLL reset held off). It then issues two writes to extended mode register 1 that enter and leave off-chip-driver calibration. After that it moves the controller into normal operation and arms a periodic refresh timer. Consecutive mode-register commands are spaced by a programmable wait, and the bus carries NOP in every cycle between them.

There is no data stream in this block, so no valid/ready handshake applies. `start` is a plain level sampled on the clock. `done` is a sticky status flag. `refresh_req` is a one-cycle strobe with no back-pressure: a consumer that misses it loses that request. All configuration inputs must be held steady from `start` until `done` rises. `refresh_count` is re-sampled at every timer reload.

Top module: `ddr2_modeinit_seq`

## Requirements
- R1: While reset is asserted, and in idle after it, the bus shows NOP: cs_n=0 and ras_n, cas_n, we_n all 1, with bank address and address lines at zero. `done` and `refresh_req` are low.
- R2: When `start` is high at an edge in idle, the next cycle carries a mode-register command: cs_n, ras_n, cas_n and we_n all 0, bank address 00. The address holds burst_len on A2:A0, 0 on A3, cas_lat on A6:A4 and 0 on A8 (DLL reset off), with all other bits 0.
- R3: The second command is a mode-register command to bank address 01. The address equals emr_bits except A9:A7, which are forced to 111 (calibration default).
- R4: The third command is a mode-register command to bank address 01. The address equals emr_bits except A9:A7, which are forced to 000 (calibration exit).
- R5: Consecutive commands start exactly T cycles apart, where T = max(tmrd_cycles, 2). Each command lasts one cycle, and the bus shows NOP with zero address in between.
- R6: `done` rises T cycles after the third command, which marks entry into normal mode. It stays high until reset, and the bus stays NOP from then on.
- R7: With refresh_count = N > 0, `refresh_req` pulses for one cycle N cycles after `done` rises and every N cycles after that. With N = 0 it never pulses.
- R8: `start` has no effect while the sequence runs or after `done` is set. Command timing is unchanged and no new command appears.
- R9: `refresh_req` is never high while `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (honoured only in idle) |
| cas_lat | input | 3 | CAS latency code for the main mode register |
| burst_len | input | 3 | Burst length code for the main mode register |
| emr_bits | input | ADDR_W | Extended mode register 1 contents; the calibration field is overridden |
| tmrd_cycles | input | TMRD_W | Command-to-command spacing, clamped to at least 2 |
| refresh_count | input | RCNT_W | Refresh interval in clocks (period times clock frequency); 0 disables |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines carrying register contents |
| refresh_req | output | 1 | One-cycle refresh request |
| done | output | 1 | Initialization complete, sticky |

## Verification
Several properties are checked on every cycle. A mode-register command is always followed by NOP. Any command to bank 01 has its calibration field all ones or all zeros. A command to bank 00 never sets the DLL-reset bit. `done` never falls outside reset, and a refresh request never appears before `done`. Other behaviour can only be shown by the bench's scenarios: the exact command order, the T-cycle spacing including the clamp of small waits, the field placement of each register word, the refresh period and its disable value, and the rejection of `start` pulses made mid-run or after completion.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr2i_cmd_t;

  localparam ddr2i_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr2i_cmd_t CMD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_NORMAL = 2'd2
  } ddr2i_state_t;

  // field positions inside the register words
  localparam int BL_LSB      = 0;
  localparam int CL_LSB      = 4;
  localparam int DLL_RST_BIT = 8;
  localparam int OCD_LSB     = 7;
  localparam int OCD_W       = 3;

  // command steps
  localparam logic [1:0] STEP_MRS      = 2'd0;
  localparam logic [1:0] STEP_OCD_DFLT = 2'd1;
  localparam logic [1:0] STEP_OCD_EXIT = 2'd2;

endpackage

// File: rtl/ddr2i_seq_fsm.sv
module ddr2i_seq_fsm
  import ddr2i_pkg::*;
#(
  parameter int TMRD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TMRD_W-1:0] tmrd_cycles,
  output logic              issue,
  output logic [1:0]        issue_step,
  output logic              arm,
  output logic              done
);

  localparam logic [TMRD_W-1:0] TMRD_MIN = TMRD_W'(2);

  ddr2i_state_t      state_q;
  logic [1:0]        step_q;
  logic [TMRD_W-1:0] wait_q;
  logic [TMRD_W-1:0] tmrd_eff;
  logic [TMRD_W-1:0] wait_load;

  assign tmrd_eff  = (tmrd_cycles < TMRD_MIN) ? TMRD_MIN : tmrd_cycles;
  assign wait_load = tmrd_eff - TMRD_W'(1);

  always_comb begin
    issue      = 1'b0;
    issue_step = step_q;
    arm        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          issue      = 1'b1;
          issue_step = STEP_MRS;
        end
      end
      ST_RUN: begin
        if (wait_q == '0) begin
          if (step_q == STEP_OCD_EXIT) begin
            arm = 1'b1;
          end else begin
            issue      = 1'b1;
            issue_step = step_q + 2'd1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_MRS;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            step_q  <= STEP_MRS;
            wait_q  <= wait_load;
          end
        end
        ST_RUN: begin
          if (wait_q == '0) begin
            if (step_q == STEP_OCD_EXIT) begin
              state_q <= ST_NORMAL;
            end else begin
              step_q <= step_q + 2'd1;
              wait_q <= wait_load;
            end
          end else begin
            wait_q <= wait_q - TMRD_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign done = (state_q == ST_NORMAL);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (issue_step <= STEP_OCD_EXIT));

endmodule

// File: rtl/ddr2i_word_build.sv
module ddr2i_word_build
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic [1:0]        step,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        burst_len,
  input  logic [ADDR_W-1:0] emr_bits,
  output logic [BA_W-1:0]   ba_word,
  output logic [ADDR_W-1:0] addr_word
);

  localparam logic [BA_W-1:0] BA_MAIN = BA_W'(0);
  localparam logic [BA_W-1:0] BA_EXT1 = BA_W'(1);

  logic [ADDR_W-1:0] main_word;
  logic [ADDR_W-1:0] ext_word;

  always_comb begin
    main_word                 = '0;
    main_word[BL_LSB +: 3]    = burst_len;
    main_word[CL_LSB +: 3]    = cas_lat;
    main_word[DLL_RST_BIT]    = 1'b0;

    ext_word                  = emr_bits;
    ext_word[OCD_LSB +: OCD_W] = (step == STEP_OCD_DFLT) ? {OCD_W{1'b1}} : {OCD_W{1'b0}};

    if (step == STEP_MRS) begin
      ba_word   = BA_MAIN;
      addr_word = main_word;
    end else begin
      ba_word   = BA_EXT1;
      addr_word = ext_word;
    end
  end

endmodule

// File: rtl/ddr2i_refresh_timer.sv
module ddr2i_refresh_timer #(
  parameter int RCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [RCNT_W-1:0] refresh_count,
  output logic              refresh_req
);

  logic [RCNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      refresh_req <= 1'b0;
    end else if (arm) begin
      cnt_q       <= refresh_count;
      refresh_req <= 1'b0;
    end else if (cnt_q == RCNT_W'(1)) begin
      cnt_q       <= refresh_count;
      refresh_req <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - RCNT_W'(1);
      refresh_req <= 1'b0;
    end
  end

  // R7
  idle_timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !arm) |=> !refresh_req);

endmodule

// File: rtl/ddr2_modeinit_seq.sv
module ddr2_modeinit_seq
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int TMRD_W = 4,
  parameter int RCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        burst_len,
  input  logic [ADDR_W-1:0] emr_bits,
  input  logic [TMRD_W-1:0] tmrd_cycles,
  input  logic [RCNT_W-1:0] refresh_count,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              refresh_req,
  output logic              done
);

  logic              issue;
  logic [1:0]        issue_step;
  logic              arm;
  logic [BA_W-1:0]   ba_word;
  logic [ADDR_W-1:0] addr_word;
  ddr2i_cmd_t        cmd_q;

  ddr2i_seq_fsm #(.TMRD_W(TMRD_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .tmrd_cycles (tmrd_cycles),
    .issue       (issue),
    .issue_step  (issue_step),
    .arm         (arm),
    .done        (done)
  );

  ddr2i_word_build #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_word (
    .step      (issue_step),
    .cas_lat   (cas_lat),
    .burst_len (burst_len),
    .emr_bits  (emr_bits),
    .ba_word   (ba_word),
    .addr_word (addr_word)
  );

  ddr2i_refresh_timer #(.RCNT_W(RCNT_W)) u_refresh (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .refresh_count (refresh_count),
    .refresh_req   (refresh_req)
  );

  // command bus register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
    end else if (issue) begin
      cmd_q <= CMD_MODE;
      ba    <= ba_word;
      addr  <= addr_word;
    end else begin
      cmd_q <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
    end
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;

  logic mode_cmd;
  assign mode_cmd = !cs_n && !ras_n && !cas_n && !we_n;

  // R5
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cmd |=> (!cs_n && ras_n && cas_n && we_n));

  // R3 R4
  ocd_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && ba == BA_W'(1)) |->
      (addr[OCD_LSB +: OCD_W] == {OCD_W{1'b1}} || addr[OCD_LSB +: OCD_W] == {OCD_W{1'b0}}));

  // R2
  dll_reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && ba == BA_W'(0)) |-> !addr[DLL_RST_BIT]);

  // R9
  refresh_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> done);

  // R6
  no_cmd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !mode_cmd);

endmodule

// File: tb/tb_ddr2_modeinit_seq.sv
module tb_ddr2_modeinit_seq;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int TMRD_W = 4;
  localparam int RCNT_W = 16;

  typedef struct packed {
    logic [2:0]        cl;
    logic [2:0]        bl;
    logic [ADDR_W-1:0] emr;
    logic [TMRD_W-1:0] tmrd;
    logic [RCNT_W-1:0] rc;
    logic              poke;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{cl: 3'd3, bl: 3'd2, emr: 13'h0044, tmrd: 4'd2, rc: 16'd3, poke: 1'b0},
    '{cl: 3'd5, bl: 3'd3, emr: 13'h1FFF, tmrd: 4'd4, rc: 16'd5, poke: 1'b1},
    '{cl: 3'd4, bl: 3'd2, emr: 13'h0000, tmrd: 4'd0, rc: 16'd1, poke: 1'b0},
    '{cl: 3'd6, bl: 3'd3, emr: 13'h0402, tmrd: 4'd3, rc: 16'd0, poke: 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        cas_lat = '0;
  logic [2:0]        burst_len = '0;
  logic [ADDR_W-1:0] emr_bits = '0;
  logic [TMRD_W-1:0] tmrd_cycles = '0;
  logic [RCNT_W-1:0] refresh_count = '0;
  logic              cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;
  logic              refresh_req;
  logic              done;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  ddr2_modeinit_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD_W(TMRD_W), .RCNT_W(RCNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(cas_lat), .burst_len(burst_len),
    .emr_bits(emr_bits), .tmrd_cycles(tmrd_cycles), .refresh_count(refresh_count),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .refresh_req(refresh_req), .done(done)
  );

  localparam logic [18:0] NOP_BUS = {4'b0111, 2'b00, 13'h0000};

  function automatic logic [18:0] bus_now();
    return {cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  function automatic logic [18:0] exp_cmd(int idx, vec_t v);
    logic [ADDR_W-1:0] a;
    if (idx == 0) begin
      a = '0;
      a[2:0] = v.bl;
      a[6:4] = v.cl;
      return {4'b0000, 2'b00, a};
    end
    a = v.emr;
    a[9:7] = (idx == 1) ? 3'b111 : 3'b000;
    return {4'b0000, 2'b01, a};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(bus_now() == NOP_BUS, req, "bus NOP", 32'(bus_now()), 32'(NOP_BUS));
    chk(done == 1'b0, req, "done low", 32'(done), 32'd0);
    chk(refresh_req == 1'b0, req, "refresh low", 32'(refresh_req), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
  endtask

  task automatic run_vec(input vec_t v);
    int t;
    t = (v.tmrd < 2) ? 2 : int'(v.tmrd);
    cas_lat       = v.cl;
    burst_len     = v.bl;
    emr_bits      = v.emr;
    tmrd_cycles   = v.tmrd;
    refresh_count = v.rc;
    do_reset();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(bus_now() == exp_cmd(i, v), (i == 0) ? "R2" : ((i == 1) ? "R3" : "R4"),
          "mode command", 32'(bus_now()), 32'(exp_cmd(i, v)));
      for (int n = 1; n < t; n++) begin
        @(negedge clk);
        if (v.poke && i == 0 && n == 2) start = 1'b0;
        chk(bus_now() == NOP_BUS, "R5", "NOP gap", 32'(bus_now()), 32'(NOP_BUS));
        chk(done == 1'b0, "R6", "done early", 32'(done), 32'd0);
        // R8: pulse start during the first gap
        if (v.poke && i == 0 && n == 1) start = 1'b1;
      end
      @(negedge clk);
    end
    chk(done == 1'b1, "R6", "done rise", 32'(done), 32'd1);
    chk(bus_now() == NOP_BUS, "R6", "bus after done", 32'(bus_now()), 32'(NOP_BUS));
    for (int j = 1; j <= 12; j++) begin
      logic exp_req;
      @(negedge clk);
      if (v.poke && j == 3) start = 1'b0;
      exp_req = (v.rc != 0) && ((j % int'(v.rc)) == 0);
      chk(refresh_req == exp_req, "R7", "refresh pulse", 32'(refresh_req), 32'(exp_req));
      chk(done == 1'b1, "R6", "done sticky", 32'(done), 32'd1);
      chk(bus_now() == NOP_BUS, "R8", "no command after done", 32'(bus_now()), 32'(NOP_BUS));
      if (v.poke && j == 2) start = 1'b1;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1: state during the very first reset
    @(negedge clk);
    chk_idle("R1");
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R1: reset in the middle of a run returns to idle
    cas_lat = 3'd3; burst_len = 3'd2; emr_bits = 13'h0010;
    tmrd_cycles = 4'd4; refresh_count = 16'd2;
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      // R9: no refresh before done
      chk(refresh_req == 1'b0 && done == 1'b0, "R9", "quiet after reset",
          32'({refresh_req, done}), 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule